// File: doc/BRIEF.md
# Fixed-Length Serial Frame Builder

This block packs payload words into fixed-length synchronous frames and sends them out one bit per clock. Each frame opens with a fixed start pattern, followed by a flag that marks the frame as filler, then the payload word, then one odd-parity bit, then a fixed stop pattern. Frames go out back to back with no idle bits between them, so a receiver can find one start pattern and then predict where every later frame begins.

Payload words come from an upstream clock-crossing FIFO that is already in this clock domain. The block takes one word per frame in a single acceptance slot: the cycle in which the last bit of the current frame is on the line. If no word is offered in that slot, the block still sends a frame. That frame repeats the last accepted word and has the filler flag set, so the far end can discard it. A strobe marks the cycle in which the first bit of each frame is on the line.

Top module: `fb_serial_framer`

## Requirements
- R1: A frame is DATA_W+12 bits long (80 bits at the default DATA_W=68). Frames follow each other with no gap. `frame_start` is high for exactly one cycle per frame, in the cycle when the first frame bit is on `ser_out`.
- R2: The first 8 bits of every frame are the start pattern 1,1,1,1,0,0,0,0, sent in that order.
- R3: Bit 9 of the frame is the filler flag: 1 when no word was accepted for this frame, 0 otherwise. The payload word follows it, most significant bit first.
- R4: The bit after the payload is the parity bit. The filler flag, the payload bits and the parity bit together contain an odd number of ones.
- R5: The last two bits of every frame are 0 then 1.
- R6: `in_ready` is high for exactly one cycle per frame, the cycle in which the last bit of the current frame is on `ser_out`. A word is accepted when `in_valid` and `in_ready` are both high, and it is sent in the very next frame.
- R7: If `in_valid` is low in the acceptance slot, the next frame carries the filler flag set and repeats the last accepted word. Before any word has been accepted, the repeated word is zero.
- R8: While `rst_n` is low, `ser_out`, `frame_start` and `in_ready` are 0. After `rst_n` rises, reset is released on the second clock edge. `in_ready` goes high in the cycle after that edge, and the first frame starts one cycle later. `ser_out` stays 0 until the first frame starts.
- R9: `in_valid` and `in_data` are ignored outside the acceptance slot. A word offered mid-frame is neither sent nor kept as the word a filler frame repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A payload word is offered |
| in_ready | output | 1 | Acceptance slot: the last bit of the current frame is on the line |
| in_data | input | DATA_W | Payload word |
| ser_out | output | 1 | Serial frame bit, most significant first |
| frame_start | output | 1 | High while the first bit of a frame is on `ser_out` |

## Verification
The bench builds the block with DATA_W=6, which gives an 18-bit frame. With a payload that small, every payload value from 0 to 63 can be sent in turn. This covers every parity weight, and it checks each frame field by field against expected bits the bench computes arithmetically. Filler frames are mixed in after every eighth word. Each frame is also preceded by a mid-frame offer of a junk word, so the test shows which word a filler frame repeats and that offers outside the acceptance slot are dropped. Frame length and field order come from the same parameter arithmetic, so the default 80-bit layout follows from the same code.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int START_W = 8;
  localparam int STOP_W  = 2;
  localparam logic [START_W-1:0] START_PAT = 8'b1111_0000;
  localparam logic [STOP_W-1:0]  STOP_PAT  = 2'b01;
  // start + filler flag + parity + stop
  localparam int OVERHEAD_W = START_W + 1 + 1 + STOP_W;
endpackage

// File: rtl/fb_reset_sync.sv
module fb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fb_parity.sv
module fb_parity #(
  parameter int W   = 69,
  parameter bit ODD = 1'b1
) (
  input  logic [W-1:0] bits,
  output logic         par
);
  generate
    if (ODD) begin : g_odd
      assign par = ~(^bits);
    end else begin : g_even
      assign par = ^bits;
    end
  endgenerate
endmodule

// File: rtl/fb_frame_assembler.sv
module fb_frame_assembler
  import fb_pkg::*;
#(
  parameter int DATA_W  = 68,
  parameter int FRAME_W = DATA_W + OVERHEAD_W
) (
  input  logic [DATA_W-1:0]  data,
  input  logic               empty,
  output logic [FRAME_W-1:0] frame
);
  logic par;

  fb_parity #(.W(DATA_W + 1), .ODD(1'b1)) u_par (
    .bits ({empty, data}),
    .par  (par)
  );

  assign frame = {START_PAT, empty, data, par, STOP_PAT};

  // R4: flag, payload and parity carry an odd count of ones
  always_comb begin
    assert_odd_weight_R4: assert (($countones(frame[FRAME_W-START_W-1:STOP_W]) % 2) == 1)
      else $error("parity field does not give odd weight");
  end
endmodule

// File: rtl/fb_slot_counter.sv
module fb_slot_counter #(
  parameter int FRAME_W = 80
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot,
  output logic first_bit
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LAST;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign slot      = (cnt_q == LAST);
  assign first_bit = (cnt_q == '0);
endmodule

// File: rtl/fb_shift_out.sv
module fb_shift_out #(
  parameter int FRAME_W = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               ser
);
  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;
  logic               sr_en;

  always_comb begin
    sr_en = 1'b1;
    sr_d  = load ? frame : {sr_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign ser = sr_q[FRAME_W-1];
endmodule

// File: rtl/fb_serial_framer.sv
module fb_serial_framer
  import fb_pkg::*;
#(
  parameter int DATA_W = 68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              ser_out,
  output logic              frame_start
);
  localparam int FRAME_W = DATA_W + OVERHEAD_W;

  logic               rst_sync_n;
  logic               slot;
  logic               first_bit;
  logic               accept;
  logic               empty;
  logic [DATA_W-1:0]  hold_q;
  logic [DATA_W-1:0]  hold_d;
  logic               hold_en;
  logic [DATA_W-1:0]  word;
  logic [FRAME_W-1:0] frame;

  fb_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fb_slot_counter #(.FRAME_W(FRAME_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .slot      (slot),
    .first_bit (first_bit)
  );

  assign in_ready = slot && rst_sync_n;
  assign accept   = in_ready && in_valid;
  assign empty    = !in_valid;

  always_comb begin
    hold_en = accept;
    hold_d  = in_data;
    word    = in_valid ? in_data : hold_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  fb_frame_assembler #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_asm (
    .data  (word),
    .empty (empty),
    .frame (frame)
  );

  fb_shift_out #(.FRAME_W(FRAME_W)) u_sh (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (in_ready),
    .frame (frame),
    .ser   (ser_out)
  );

  assign frame_start = first_bit && rst_sync_n;

  // Used only by the checks below: set once the first frame has begun.
  logic seen_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)      seen_q <= 1'b0;
    else if (frame_start) seen_q <= 1'b1;
  end

  assert_start_after_slot_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start |-> $past(in_ready));

  assert_single_slot_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_ready |=> !in_ready);

  assert_start_msb_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start |-> (ser_out == START_PAT[START_W-1]));

  assert_stop_lsb_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_ready && seen_q) |-> (ser_out == STOP_PAT[0]));

  assert_quiet_line_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!seen_q && !frame_start) |-> !ser_out);

  assert_hold_on_filler_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_ready && !in_valid) |=> $stable(hold_q));

  assert_mid_frame_ignored_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_ready |=> $stable(hold_q));
endmodule

// File: tb/fb_serial_framer_tb.sv
module fb_serial_framer_tb;
  localparam int DW = 6;
  localparam int FW = DW + 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          ser_out;
  logic          frame_start;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  fb_serial_framer #(.DATA_W(DW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .ser_out     (ser_out),
    .frame_start (frame_start)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      finish_run();
    end
  end

  initial begin
    logic [FW-1:0] got;
    logic [DW-1:0] last;
    logic [DW-1:0] exp_d;
    logic          exp_e;
    logic          exp_p;
    int            vcount;
    bit            strobe_ok;
    bit            ready_ok;
    bit            quiet_ok;

    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    #1;
    // R8: outputs quiet during reset
    check(ser_out == 1'b0 && frame_start == 1'b0 && in_ready == 1'b0, "R8",
          {ser_out, frame_start, in_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0 && ser_out == 1'b0, "R8", {in_ready, ser_out}, 0);
    @(negedge clk);
    check(in_ready == 1'b1 && ser_out == 1'b0 && frame_start == 1'b0, "R8",
          {in_ready, ser_out, frame_start}, 3'b100);

    last   = '0;
    vcount = 0;
    for (int k = 0; k <= 72; k++) begin
      // at the acceptance slot
      if (k == 0 || (k % 9) == 0) begin
        in_valid = 1'b0;
        in_data  = 6'h15;
        exp_e    = 1'b1;
        exp_d    = last;
      end else begin
        in_valid = 1'b1;
        in_data  = DW'(vcount);
        exp_e    = 1'b0;
        exp_d    = DW'(vcount);
        last     = DW'(vcount);
        vcount++;
      end
      exp_p     = (($countones({exp_e, exp_d}) % 2) == 0);
      strobe_ok = 1'b1;
      ready_ok  = 1'b1;
      got       = '0;
      for (int i = 0; i < FW; i++) begin
        @(negedge clk);
        got = {got[FW-2:0], ser_out};
        if (frame_start != (i == 0)) strobe_ok = 1'b0;
        if (in_ready != (i == FW - 1)) ready_ok = 1'b0;
        if (i == 0) in_valid = 1'b0;
        if (i == 4) begin
          in_valid = 1'b1;
          in_data  = ~last;
        end
        if (i == 8) in_valid = 1'b0;
      end
      check(strobe_ok, "R1", strobe_ok, 1);
      check(ready_ok, "R6", ready_ok, 1);
      check(got[FW-1 -: 8] == 8'hF0, "R2", got[FW-1 -: 8], 8'hF0);
      check(got[FW-9] == exp_e, exp_e ? "R7" : "R3", got[FW-9], exp_e);
      check(got[FW-10 -: DW] == exp_d, exp_e ? "R7 R9" : "R3 R9", got[FW-10 -: DW], exp_d);
      check(got[2] == exp_p, "R4", got[2], exp_p);
      check(got[1:0] == 2'b01, "R5", got[1:0], 2'b01);
    end

    // R8: asynchronous reset mid-frame silences the line at once
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    quiet_ok = (ser_out == 1'b0 && frame_start == 1'b0 && in_ready == 1'b0);
    check(quiet_ok, "R8", {ser_out, frame_start, in_ready}, 0);

    done = 1'b1;
    finish_run();
  end
endmodule